// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This host-side controller works out what a flash device is doing by reading its status twice and comparing two toggle bits between the reads. On a request it latches a sector address and a flag saying whether the last command was a program or an erase. It then pulses the address-valid strobe, performs one status read, pulses the strobe again and performs a second read. Each read uses a simple request/acknowledge handshake.

From the two samples it forms two toggle indications: one for the bit that flips while any embedded operation runs, and one for the bit that flips only inside sectors chosen for erasure. It reduces them to a single class. The class is presented with a one-cycle completion pulse and stays on the output until the next decision. A request is taken only while the controller is idle and the command-write strobe is no longer active.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy_o`, `avd_o`, `rd_req_o` and `done_o` are 0 and `class_o` is 0 (done/array data).
- R2: `req_i` starts a poll only in a cycle where the controller is idle and `wr_busy_i` is 0. A request made while `wr_busy_i` is 1, or while a poll is running, has no effect.
- R3: A poll runs as follows. A one-cycle `avd_o` pulse comes in the cycle after the request is accepted. `rd_req_o` is then held until a cycle with `rd_ack_i` high. A second one-cycle `avd_o` pulse follows, then the second read. `rd_req_o` never rises without an `avd_o` pulse in the cycle before it.
- R4: `bus_addr_o` carries the address latched at acceptance for the whole poll, even when `addr_i` changes.
- R5: If data bit 6 and data bit 2 both differ between the two reads, the class is 2 (erasing the addressed sector).
- R6: If only bit 6 differs, the class is 3 (erasing another sector) when `op_erase_i` was 1 at acceptance, and 1 (programming) when it was 0.
- R7: If only bit 2 differs, the class is 4 (addressed sector erase-suspended).
- R8: If neither bit differs, the class is 0 (done, or array data).
- R9: `done_o` is high for exactly one cycle, in the cycle after the second acknowledge. `class_o` changes only in that cycle and holds its value afterwards. Data bits other than 6 and 2 do not affect the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request a status poll |
| addr_i | input | ADDR_W | Sector address to poll |
| op_erase_i | input | 1 | 1 when the last command was an erase, 0 when it was a program |
| wr_busy_i | input | 1 | Final command write strobe still active |
| avd_o | output | 1 | Address-valid strobe pulse that relatches the address |
| bus_addr_o | output | ADDR_W | Address presented to the device |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid with it |
| rd_data_i | input | DATA_W | Status word returned by the read |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle decision pulse |
| class_o | output | 3 | Decided class: 0 done, 1 program, 2 erase here, 3 erase elsewhere, 4 suspended here |

## Verification
The hardest situations to reach are a request that arrives while the controller is busy, and an address that changes mid-poll. Both are hidden unless the request line is kept high across a whole poll and the address is swapped between the reads. The bench does both. It then checks that exactly one strobe pair appears and that the bus address stays fixed. Read latency is varied from zero to several cycles, so a read can end in the cycle it starts or after waiting. The bit-6-only case is run with both values of the operation flag. Status words where unrelated bits flip are included to show that those bits leave the class alone.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    PC_DONE        = 3'd0,
    PC_PROG        = 3'd1,
    PC_ERASE_HERE  = 3'd2,
    PC_ERASE_OTHER = 3'd3,
    PC_SUSP_HERE   = 3'd4
  } poll_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE1,
    ST_READ1,
    ST_STROBE2,
    ST_READ2,
    ST_DECIDE
  } poll_state_e;

  // Map the two toggle indications to a class (R5..R8)
  function automatic poll_class_e classify(input logic tog_any,
                                           input logic tog_sector,
                                           input logic was_erase);
    poll_class_e c;
    if (tog_any && tog_sector)       c = PC_ERASE_HERE;
    else if (tog_any)                c = was_erase ? PC_ERASE_OTHER : PC_PROG;
    else if (tog_sector)             c = PC_SUSP_HERE;
    else                             c = PC_DONE;
    return c;
  endfunction

endpackage

// File: rtl/tpoll_seq.sv
module tpoll_seq
  import tpoll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic wr_busy_i,
  input  logic rd_ack_i,
  output logic start_o,
  output logic avd_o,
  output logic rd_req_o,
  output logic cap1_o,
  output logic cap2_o,
  output logic done_o,
  output logic busy_o
);

  poll_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i && !wr_busy_i) state_d = ST_STROBE1;
      ST_STROBE1: state_d = ST_READ1;
      ST_READ1:   if (rd_ack_i) state_d = ST_STROBE2;
      ST_STROBE2: state_d = ST_READ2;
      ST_READ2:   if (rd_ack_i) state_d = ST_DECIDE;
      ST_DECIDE:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign start_o  = (state_q == ST_IDLE) && req_i && !wr_busy_i;
  assign avd_o    = (state_q == ST_STROBE1) || (state_q == ST_STROBE2);
  assign rd_req_o = (state_q == ST_READ1) || (state_q == ST_READ2);
  assign cap1_o   = (state_q == ST_READ1) && rd_ack_i;
  assign cap2_o   = (state_q == ST_READ2) && rd_ack_i;
  assign done_o   = (state_q == ST_DECIDE);
  assign busy_o   = (state_q != ST_IDLE);

endmodule

// File: rtl/tpoll_capture.sv
module tpoll_capture
  import tpoll_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int ANY_BIT = 6,
  parameter int SEC_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              op_erase_i,
  input  logic              cap1_i,
  input  logic              cap2_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [2:0]        class_o
);

  logic        op_erase_q;
  logic [1:0]  first_q;
  logic        tog_any, tog_sec;
  poll_class_e class_q;
  logic        unused_data_bits;

  assign unused_data_bits = ^rd_data_i;
  assign tog_any = first_q[1] ^ rd_data_i[ANY_BIT];
  assign tog_sec = first_q[0] ^ rd_data_i[SEC_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q_o   <= '0;
      op_erase_q <= 1'b0;
      first_q    <= '0;
      class_q    <= PC_DONE;
    end else begin
      if (start_i) begin
        addr_q_o   <= addr_i;
        op_erase_q <= op_erase_i;
      end
      if (cap1_i) first_q <= {rd_data_i[ANY_BIT], rd_data_i[SEC_BIT]};
      if (cap2_i) class_q <= classify(tog_any, tog_sec, op_erase_q);
    end
  end

  assign class_o = class_q;

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int ANY_BIT = 6,
  parameter int SEC_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              op_erase_i,
  input  logic              wr_busy_i,
  output logic              avd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        class_o
);

  logic start_w, cap1_w, cap2_w;

  tpoll_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .wr_busy_i (wr_busy_i),
    .rd_ack_i  (rd_ack_i),
    .start_o   (start_w),
    .avd_o     (avd_o),
    .rd_req_o  (rd_req_o),
    .cap1_o    (cap1_w),
    .cap2_o    (cap2_w),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );

  tpoll_capture #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ANY_BIT (ANY_BIT),
    .SEC_BIT (SEC_BIT)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_w),
    .addr_i     (addr_i),
    .op_erase_i (op_erase_i),
    .cap1_i     (cap1_w),
    .cap2_i     (cap2_w),
    .rd_data_i  (rd_data_i),
    .addr_q_o   (bus_addr_o),
    .class_o    (class_o)
  );

endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              wr_busy_i,
  input logic              avd_o,
  input logic              rd_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [2:0]        class_o,
  input logic [ADDR_W-1:0] bus_addr_o
);

  p_read_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_o) |-> $past(avd_o));

  p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    avd_o |=> !avd_o);

  p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i && !wr_busy_i));

  p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_class_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(class_o) |-> done_o);

  p_class_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    class_o <= 3'd4);

endmodule

bind toggle_poll_ctrl tpoll_checker #(.ADDR_W(ADDR_W)) u_tpoll_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .wr_busy_i  (wr_busy_i),
  .avd_o      (avd_o),
  .rd_req_o   (rd_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .class_o    (class_o),
  .bus_addr_o (bus_addr_o)
);

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          op_erase_i = 1'b0;
  logic          wr_busy_i = 1'b0;
  logic          avd_o, rd_req_o, busy_o, done_o;
  logic [AW-1:0] bus_addr_o;
  logic          rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic [2:0]    class_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int last_class = 0;

  always #4 clk = ~clk;

  toggle_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .op_erase_i(op_erase_i), .wr_busy_i(wr_busy_i), .avd_o(avd_o),
    .bus_addr_o(bus_addr_o), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .class_o(class_o)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // Reference decision written from the requirement text
  function automatic int expect_class(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                      input bit erase);
    bit six_moved, two_moved;
    six_moved = (a[6] != b[6]);
    two_moved = (a[2] != b[2]);
    if (six_moved && two_moved) return 2;   // R5
    if (six_moved) return erase ? 3 : 1;    // R6
    if (two_moved) return 4;                // R7
    return 0;                               // R8
  endfunction

  // One read phase; entered at the negedge of the first read cycle
  task automatic serve_read(input int lat, input logic [DW-1:0] word, input logic [AW-1:0] a);
    for (int i = 0; i < lat; i++) begin
      check(rd_req_o === 1'b1 && avd_o === 1'b0, "R3 read held", rd_req_o, 1);
      check(bus_addr_o === a, "R4 address held", bus_addr_o, a);
      check(class_o === last_class[2:0], "R9 class steady", class_o, last_class);
      rd_ack_i = 1'b0;
      @(negedge clk);
    end
    check(rd_req_o === 1'b1, "R3 read request", rd_req_o, 1);
    check(bus_addr_o === a, "R4 address held", bus_addr_o, a);
    rd_ack_i  = 1'b1;
    rd_data_i = word;
    @(negedge clk);
    rd_ack_i  = 1'b0;
    rd_data_i = ~word;
  endtask

  task automatic poll(input logic [AW-1:0] a, input bit erase, input logic [DW-1:0] w1,
                      input logic [DW-1:0] w2, input int lat, input bit hold_req, input string tag);
    int exp;
    exp = expect_class(w1, w2, erase);
    req_i = 1'b1; addr_i = a; op_erase_i = erase;
    @(negedge clk);
    check(avd_o === 1'b1 && rd_req_o === 1'b0 && busy_o === 1'b1, "R3 first strobe", avd_o, 1);
    check(bus_addr_o === a, "R4 latched address", bus_addr_o, a);
    if (!hold_req) req_i = 1'b0;
    addr_i = ~a; op_erase_i = ~erase;   // changes after acceptance must not matter
    @(negedge clk);
    serve_read(lat, w1, a);
    check(avd_o === 1'b1 && rd_req_o === 1'b0, "R3 second strobe", avd_o, 1);
    check(done_o === 1'b0, "R9 no early done", done_o, 0);
    @(negedge clk);
    serve_read(lat, w2, a);
    check(done_o === 1'b1, {"R9 done pulse ", tag}, done_o, 1);
    check(int'(class_o) == exp, {"class ", tag}, class_o, exp);
    req_i = 1'b0;
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R9 done one cycle", done_o, 0);
    check(int'(class_o) == exp, "R9 class held", class_o, exp);
    check(avd_o === 1'b0, "R2 no restart after poll", avd_o, 0);
    last_class = exp;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o === 1'b0 && avd_o === 1'b0 && rd_req_o === 1'b0 && done_o === 1'b0,
          "R1 idle outputs", {busy_o, avd_o, rd_req_o, done_o}, 0);
    check(class_o === 3'd0, "R1 class", class_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 request ignored while the command write strobe is active
    wr_busy_i = 1'b1; req_i = 1'b1; addr_i = 24'h00_1234;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(avd_o === 1'b0 && busy_o === 1'b0, "R2 gated by wr_busy", busy_o, 0);
    end
    req_i = 1'b0; wr_busy_i = 1'b0;
    @(negedge clk);

    // R5..R8 and R6 both op flags, various latencies
    poll(24'h12_3400, 1'b1, 16'h0044, 16'h0000, 0, 1'b0, "R5 erase here");
    poll(24'h00_0800, 1'b1, 16'h0040, 16'h0000, 1, 1'b0, "R6 erase other");
    poll(24'h00_0800, 1'b0, 16'h0000, 16'h0040, 2, 1'b0, "R6 program");
    poll(24'hAB_0000, 1'b1, 16'h0004, 16'h0000, 3, 1'b0, "R7 suspended");
    poll(24'hAB_0000, 1'b1, 16'h00FF, 16'h00FF, 1, 1'b0, "R8 done");
    // R9 other bits flipping only
    poll(24'h55_5555, 1'b0, 16'hFF00, 16'h00BB, 2, 1'b0, "R9 other bits ignored");
    // R2 request held through a whole poll: exactly one strobe pair
    poll(24'h0F_0F0F, 1'b0, 16'h0040, 16'h0004, 1, 1'b1, "R5 with held request");
    poll(24'h0F_0F0F, 1'b1, 16'h1234, 16'h1230, 0, 1'b0, "R7 zero latency");
    poll(24'h0F_0F0F, 1'b1, 16'h1234, 16'h1234, 0, 1'b0, "R8 steady");

    // R1 reset returns to idle with class cleared
    rst_n = 1'b0;
    @(negedge clk);
    check(class_o === 3'd0 && busy_o === 1'b0, "R1 reset again", class_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule